// File: doc/BRIEF.md
# Linked-Descriptor Card DMA Engine

This block moves a transfer's worth of bytes between word-wide system memory and the byte stream of a memory card. Software builds a chain of descriptors in memory and places the address of the first one in a base register. Each descriptor occupies four consecutive 32-bit words: a status word, the buffer length in bytes, the buffer address and the address of the following descriptor. When a command is loaded, the engine walks the chain. For each descriptor it reads all four words and works out how many bytes it will move. It then streams the buffer out to the card for a write command, or fills it from the card for a read command. Finally it stores the status word back with the ownership flag dropped.

The walk stops at a descriptor whose last flag is set, or as soon as the remaining byte count reaches zero. At that point the engine raises a one-cycle completion pulse. The pulse carries the raw interrupt bits that the surrounding status logic ORs into its raw register. The engine also keeps its own DMA status register, which software clears by writing ones. After each descriptor it reports how many bytes were moved, so that the owner of the byte count and transfer counter can lower both.

Top module: `sdma_chain_dma`

## Requirements
- R1: A load request starts a walk only when DMA enable, byte count and block size are all nonzero. A read (write flag 0) also needs the card's data-ready input. Otherwise the request is ignored: no memory access, no completion and no status change.
- R2: Each descriptor is fetched as four word reads at offsets +0, +4, +8 and +12 from its address, in that order. The words are status, length, buffer address and next address.
- R3: A length of 0, or a length above MAX_DESC_BYTES, is treated as MAX_DESC_BYTES.
- R4: The bytes taken from a descriptor are the smaller of its effective length and the remaining byte count. Bits 1:0 of the buffer address are ignored, and every memory access is word aligned.
- R5: For a write command, buffer bytes go to the card in rising address order. Byte k of a memory word is bits 8k+7:8k.
- R6: For a read command, card bytes are packed in the same little-endian order into buffer words. Byte enables cover only the bytes received, so untouched bytes of a partial word keep their old value.
- R7: After its data, each descriptor's status word is written back to the descriptor address with bit 31 (owned) cleared and every other bit unchanged.
- R8: If bit 2 (last) of the status word is clear, the walk goes on at the next-descriptor address. If it is set, the walk ends there.
- R9: If the remaining byte count reaches zero at a descriptor without the last flag, the walk still ends there and completes normally. Later descriptors are not touched.
- R10: On completion the engine gives a one-cycle pulse with raw bits 3 and 16 set. The cycle after, the DMA status register has bit 8 set, plus bit 0 for a write or bit 1 for a read.
- R11: A write to the DMA status register clears those of bits 9:0 that are written as 1. Bits written as 0, and bits 31:10 of the written value, have no effect.
- R12: Per descriptor the engine reports the bytes moved. The remaining byte count never rises during a walk, and it ends at the load value minus the total moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_load | input | 1 | One-cycle request to start a walk |
| cmd_write | input | 1 | 1: memory to card, 0: card to memory |
| dma_enable | input | 1 | DMA enable from the global control register |
| byte_count | input | CNT_W | Total bytes of the transfer |
| block_size | input | BLK_W | Card block size (only tested for zero) |
| desc_base | input | ADDR_W | Address of the first descriptor |
| card_data_ready | input | 1 | Card has read data available |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write access |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted and completed this cycle |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | Engine takes the offered byte |
| stat_wr | input | 1 | Write strobe of the DMA status register |
| stat_wdata | input | 32 | Write-one-to-clear value |
| dma_status | output | 32 | DMA status register |
| busy | output | 1 | A walk is in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| raw_set | output | 32 | Raw interrupt bits to set, valid with xfer_done |
| moved_valid | output | 1 | A descriptor has been finished |
| moved_bytes | output | CNT_W | Bytes moved by that descriptor |
| bytes_left | output | CNT_W | Remaining byte count |

## Verification
Several properties are checked on every cycle. Memory accesses stay word aligned, and each write-back carries a cleared ownership bit with full byte enables. The two stream directions are never active together, and the remaining count never rises within a walk. A walk only starts from an enabled, nonzero setup. Each completion pulse lasts one cycle and leaves the summary bit and the correct direction bit in the status register. Only the bench's scenarios can show the rest. That covers the byte order on each side and the clamped, zero and minimum-limited lengths. It also covers the chain following or stopping early, partial-word byte enables, untouched later descriptors and the write-one-to-clear behaviour of the status register.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_BUFRD,
    ST_TX,
    ST_RX,
    ST_BUFWR,
    ST_WBACK,
    ST_DONE
  } sdma_state_e;

  // Descriptor status word bit positions
  localparam int unsigned DSC_OWNED = 31;
  localparam int unsigned DSC_LAST  = 2;

  // DMA status register bit positions
  localparam int unsigned DST_TX    = 0;
  localparam int unsigned DST_RX    = 1;
  localparam int unsigned DST_SUM   = 8;
  localparam int unsigned DST_CLR_W = 10;

  // Raw interrupt bits raised on completion
  localparam logic [31:0] RAW_DONE_MASK = (32'h1 << 3) | (32'h1 << 16);

  // Effective descriptor length: zero or oversize means the maximum
  function automatic logic [31:0] sdma_clamp(input logic [31:0] len,
                                             input logic [31:0] maxb);
    return ((len == 32'd0) || (len > maxb)) ? maxb : len;
  endfunction

  // Bytes taken from one descriptor
  function automatic logic [31:0] sdma_take(input logic [31:0] len,
                                            input logic [31:0] rem,
                                            input logic [31:0] maxb);
    logic [31:0] eff;
    eff = sdma_clamp(len, maxb);
    return (eff < rem) ? eff : rem;
  endfunction

endpackage

// File: rtl/sdma_lane_buf.sv
module sdma_lane_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        ld,
  input  logic [31:0] ld_word,
  input  logic        push,
  input  logic [7:0]  push_byte,
  input  logic        step,
  output logic [31:0] word_q,
  output logic [3:0]  be_q,
  output logic [1:0]  lane_q,
  output logic [7:0]  out_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      be_q   <= '0;
      lane_q <= '0;
    end else if (clr) begin
      be_q   <= '0;
      lane_q <= '0;
    end else if (ld) begin
      word_q <= ld_word;
      lane_q <= '0;
    end else if (push) begin
      word_q[{lane_q, 3'b000} +: 8] <= push_byte;
      be_q[lane_q]                  <= 1'b1;
      lane_q                        <= lane_q + 2'd1;
    end else if (step) begin
      lane_q <= lane_q + 2'd1;
    end
  end

  assign out_byte = word_q[{lane_q, 3'b000} +: 8];

endmodule

// File: rtl/sdma_dstat_reg.sv
module sdma_dstat_reg
  import sdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_ev,
  input  logic        set_wr,
  input  logic        clr_wr,
  input  logic [31:0] clr_data,
  output logic [31:0] q
);

  localparam logic [31:0] CLR_MASK = (32'h1 << DST_CLR_W) - 32'h1;

  logic [31:0] clr_m;
  logic [31:0] set_m;

  assign clr_m = clr_wr ? (clr_data & CLR_MASK) : 32'h0;
  assign set_m = set_ev ? ((32'h1 << DST_SUM) |
                           (set_wr ? (32'h1 << DST_TX) : (32'h1 << DST_RX)))
                        : 32'h0;

  // A completion in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_m) | set_m;
  end

endmodule

// File: rtl/sdma_chain_dma.sv
module sdma_chain_dma
  import sdma_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned CNT_W          = 32,
  parameter int unsigned BLK_W          = 16,
  parameter int unsigned MAX_DESC_BYTES = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_load,
  input  logic              cmd_write,
  input  logic              dma_enable,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic [BLK_W-1:0]  block_size,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic              card_data_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_data,
  input  logic              card_tx_ready,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_data,
  output logic              card_rx_ready,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  output logic [31:0]       dma_status,
  output logic              busy,
  output logic              xfer_done,
  output logic [31:0]       raw_set,
  output logic              moved_valid,
  output logic [CNT_W-1:0]  moved_bytes,
  output logic [CNT_W-1:0]  bytes_left
);

  localparam int unsigned SZ_W = $clog2(MAX_DESC_BYTES + 1);
  localparam logic [31:0] MAXB = 32'(MAX_DESC_BYTES);

  sdma_state_e       state_q;
  logic [ADDR_W-1:0] desc_addr_q;
  logic [1:0]        widx_q;
  logic [31:0]       dstat_q;
  logic [31:0]       dlen_q;
  logic [ADDR_W-1:0] dbuf_q;
  logic [ADDR_W-1:0] dnext_q;
  logic [CNT_W-1:0]  rem_q;
  logic [SZ_W-1:0]   chunk_q;
  logic [SZ_W-1:0]   take_q;
  logic [SZ_W-1:0]   boff_q;
  logic              dir_wr_q;

  // Named events for the checker
  logic              start_ok;
  logic              tx_fire;
  logic              rx_fire;
  logic              ev_wback;
  logic              dir_wr;
  logic [31:0]       take_w;
  logic [ADDR_W-1:0] buf_base;

  logic        lb_clr, lb_ld, lb_push, lb_step;
  logic [31:0] lb_word;
  logic [3:0]  lb_be;
  logic [1:0]  lb_lane;
  logic [7:0]  lb_byte;

  assign start_ok = cmd_load && (state_q == ST_IDLE) && dma_enable &&
                    (byte_count != '0) && (block_size != '0) &&
                    (cmd_write || card_data_ready);
  assign tx_fire  = (state_q == ST_TX) && card_tx_ready;
  assign rx_fire  = (state_q == ST_RX) && card_rx_valid;
  assign take_w   = sdma_take(dlen_q, 32'(rem_q), MAXB);
  assign buf_base = {dbuf_q[ADDR_W-1:2], 2'b00};
  assign dir_wr   = dir_wr_q;
  assign ev_wback = (state_q == ST_WBACK) && mem_req;

  assign lb_ld   = (state_q == ST_BUFRD) && mem_ack;
  assign lb_clr  = ((state_q == ST_DESC) && mem_ack && (widx_q == 2'd3)) ||
                   ((state_q == ST_BUFWR) && mem_ack);
  assign lb_push = rx_fire;
  assign lb_step = tx_fire;

  sdma_lane_buf u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (lb_clr),
    .ld       (lb_ld),
    .ld_word  (mem_rdata),
    .push     (lb_push),
    .push_byte(card_rx_data),
    .step     (lb_step),
    .word_q   (lb_word),
    .be_q     (lb_be),
    .lane_q   (lb_lane),
    .out_byte (lb_byte)
  );

  sdma_dstat_reg u_dstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (xfer_done),
    .set_wr  (dir_wr_q),
    .clr_wr  (stat_wr),
    .clr_data(stat_wdata),
    .q       (dma_status)
  );

  // Memory master
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    unique case (state_q)
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr_q + ADDR_W'({widx_q, 2'b00});
      end
      ST_BUFRD: begin
        mem_req  = 1'b1;
        mem_addr = buf_base + ADDR_W'(boff_q);
      end
      ST_BUFWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_base + ADDR_W'(boff_q);
        mem_wdata = lb_word;
        mem_be    = lb_be;
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = desc_addr_q;
        mem_wdata = dstat_q & ~(32'h1 << DSC_OWNED);
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  // Walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      desc_addr_q <= '0;
      widx_q      <= '0;
      dstat_q     <= '0;
      dlen_q      <= '0;
      dbuf_q      <= '0;
      dnext_q     <= '0;
      rem_q       <= '0;
      chunk_q     <= '0;
      take_q      <= '0;
      boff_q      <= '0;
      dir_wr_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            rem_q       <= byte_count;
            desc_addr_q <= desc_base;
            widx_q      <= '0;
            dir_wr_q    <= cmd_write;
            state_q     <= ST_DESC;
          end
        end
        ST_DESC: begin
          if (mem_ack) begin
            widx_q <= widx_q + 2'd1;
            unique case (widx_q)
              2'd0: dstat_q <= mem_rdata;
              2'd1: dlen_q  <= mem_rdata;
              2'd2: dbuf_q  <= mem_rdata[ADDR_W-1:0];
              default: begin
                dnext_q <= mem_rdata[ADDR_W-1:0];
                chunk_q <= SZ_W'(take_w);
                take_q  <= SZ_W'(take_w);
                boff_q  <= '0;
                state_q <= dir_wr_q ? ST_BUFRD : ST_RX;
              end
            endcase
          end
        end
        ST_BUFRD: begin
          if (mem_ack) state_q <= ST_TX;
        end
        ST_TX: begin
          if (tx_fire) begin
            chunk_q <= chunk_q - SZ_W'(1);
            rem_q   <= rem_q - CNT_W'(1);
            if (chunk_q == SZ_W'(1)) begin
              state_q <= ST_WBACK;
            end else if (lb_lane == 2'd3) begin
              boff_q  <= boff_q + SZ_W'(4);
              state_q <= ST_BUFRD;
            end
          end
        end
        ST_RX: begin
          if (rx_fire) begin
            chunk_q <= chunk_q - SZ_W'(1);
            rem_q   <= rem_q - CNT_W'(1);
            if ((chunk_q == SZ_W'(1)) || (lb_lane == 2'd3)) state_q <= ST_BUFWR;
          end
        end
        ST_BUFWR: begin
          if (mem_ack) begin
            boff_q  <= boff_q + SZ_W'(4);
            state_q <= (chunk_q == '0) ? ST_WBACK : ST_RX;
          end
        end
        ST_WBACK: begin
          if (mem_ack) begin
            if (dstat_q[DSC_LAST] || (rem_q == '0)) begin
              state_q <= ST_DONE;
            end else begin
              desc_addr_q <= dnext_q;
              widx_q      <= '0;
              state_q     <= ST_DESC;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign card_tx_valid = (state_q == ST_TX);
  assign card_tx_data  = lb_byte;
  assign card_rx_ready = (state_q == ST_RX);
  assign busy          = (state_q != ST_IDLE);
  assign xfer_done     = (state_q == ST_DONE);
  assign raw_set       = xfer_done ? RAW_DONE_MASK : 32'h0;
  assign moved_valid   = (state_q == ST_WBACK) && mem_ack;
  assign moved_bytes   = CNT_W'(take_q);
  assign bytes_left    = rem_q;

endmodule

// File: rtl/sdma_chain_dma_chk.sv
module sdma_chain_dma_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BLK_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be,
  input logic              ev_wback,
  input logic              card_tx_valid,
  input logic              card_rx_ready,
  input logic              xfer_done,
  input logic              dir_wr,
  input logic [31:0]       dma_status,
  input logic              busy,
  input logic [CNT_W-1:0]  bytes_left,
  input logic              dma_enable,
  input logic [CNT_W-1:0]  byte_count,
  input logic [BLK_W-1:0]  block_size
);

  p_start_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(dma_enable) && ($past(byte_count) != '0) &&
                     ($past(block_size) != '0)));

  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  p_one_direction_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(card_tx_valid && card_rx_ready));

  p_wback_owned_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wback |-> (mem_we && !mem_wdata[31] && (mem_be == 4'hF)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  p_done_summary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> dma_status[8]);

  p_done_dir_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (dir_wr ? dma_status[0] : dma_status[1]));

  p_left_monotonic_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bytes_left <= $past(bytes_left)));

endmodule

bind sdma_chain_dma sdma_chain_dma_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .BLK_W (BLK_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_be       (mem_be),
  .ev_wback     (ev_wback),
  .card_tx_valid(card_tx_valid),
  .card_rx_ready(card_rx_ready),
  .xfer_done    (xfer_done),
  .dir_wr       (dir_wr),
  .dma_status   (dma_status),
  .busy         (busy),
  .bytes_left   (bytes_left),
  .dma_enable   (dma_enable),
  .byte_count   (byte_count),
  .block_size   (block_size)
);

// File: tb/sdma_chain_dma_tb.sv
module sdma_chain_dma_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 64;
  localparam int DESC0      = 32'h100;
  localparam int BUF0       = 32'h200;

  typedef struct packed {
    logic        wr;
    logic        mis;
    logic [2:0]  last;
    logic [15:0] bc;
    logic [15:0] s0;
    logic [15:0] s1;
    logic [15:0] s2;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 3'b001, 16'd10,  16'd16, 16'd0,    16'd0 },  // single desc, write
    '{1'b1, 1'b0, 3'b100, 16'd40,  16'd12, 16'd20,   16'd100}, // chain of three
    '{1'b0, 1'b0, 3'b001, 16'd7,   16'd0,  16'd0,    16'd0 },  // partial word read
    '{1'b0, 1'b1, 3'b100, 16'd150, 16'd0,  16'd1000, 16'd30},  // zero/oversize, misaligned
    '{1'b1, 1'b0, 3'b000, 16'd16,  16'd8,  16'd8,    16'd8 },  // count runs out, no last
    '{1'b0, 1'b0, 3'b010, 16'd5,   16'd3,  16'd3,    16'd3 },  // read, count runs out
    '{1'b1, 1'b0, 3'b010, 16'd70,  16'd0,  16'd5,    16'd0 }   // last before count ends
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_load = 1'b0, cmd_write = 1'b0, dma_enable = 1'b0;
  logic [31:0] byte_count = '0;
  logic [15:0] block_size = '0;
  logic [31:0] desc_base = '0;
  logic        card_data_ready = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        card_tx_valid, card_rx_ready;
  logic [7:0]  card_tx_data, card_rx_data;
  logic        card_tx_ready = 1'b1, card_rx_valid = 1'b1;
  logic        stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] dma_status, raw_set;
  logic        busy, xfer_done, moved_valid;
  logic [31:0] moved_bytes, bytes_left;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_chain_dma #(.MAX_DESC_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_write(cmd_write),
    .dma_enable(dma_enable), .byte_count(byte_count), .block_size(block_size),
    .desc_base(desc_base), .card_data_ready(card_data_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .card_tx_valid(card_tx_valid),
    .card_tx_data(card_tx_data), .card_tx_ready(card_tx_ready),
    .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
    .card_rx_ready(card_rx_ready), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .dma_status(dma_status), .busy(busy), .xfer_done(xfer_done),
    .raw_set(raw_set), .moved_valid(moved_valid), .moved_bytes(moved_bytes),
    .bytes_left(bytes_left)
  );

  // Memory model, zero wait state
  logic [31:0] mem [0:1023];
  logic        tb_we = 1'b0;
  logic [9:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] wpat(input int a);
    return 8'(a & 255) ^ 8'h3C;
  endfunction

  // Card and bus monitors
  logic        log_clr = 1'b0;
  int          txn, rxn, rdn, reqn, msum;
  logic [7:0]  txlog [0:255];
  logic [31:0] rdlog [0:7];

  assign card_rx_data = pat(rxn);

  always @(posedge clk) begin
    if (log_clr) begin
      txn <= 0; rxn <= 0; rdn <= 0; reqn <= 0; msum <= 0;
    end else begin
      if (card_tx_valid && card_tx_ready) begin
        txlog[txn[7:0]] <= card_tx_data;
        txn <= txn + 1;
      end
      if (card_rx_valid && card_rx_ready) rxn <= rxn + 1;
      if (mem_req) reqn <= reqn + 1;
      if (mem_req && !mem_we && rdn < 8) begin
        rdlog[rdn] <= mem_addr;
        rdn <= rdn + 1;
      end
      if (moved_valid) msum <= msum + int'(moved_bytes);
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int byte_addr, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = 10'(byte_addr >> 2); tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  function automatic logic [7:0] peekb(input int a);
    logic [31:0] w;
    w = mem[a >> 2];
    return w[8*(a & 3) +: 8];
  endfunction

  task automatic clear_logs();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic stat_write(input logic [31:0] d);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = d;
    @(negedge clk); stat_wr = 1'b0; stat_wdata = '0;
  endtask

  task automatic pulse_load();
    @(negedge clk); cmd_load = 1'b1;
    @(negedge clk); cmd_load = 1'b0;
  endtask

  function automatic int dlen(input vec_t v, input int k);
    return (k == 0) ? int'(v.s0) : (k == 1) ? int'(v.s1) : int'(v.s2);
  endfunction

  function automatic logic [31:0] dstat(input vec_t v, input int k);
    logic [31:0] s;
    s = 32'h8000_0010;
    if (v.last[k]) s |= 32'h4;
    if (k == 0)    s |= 32'h8;
    if (k == 1)    s |= 32'h4000_0000;
    if (k == 2)    s |= 32'h2;
    return s;
  endfunction

  task automatic run_vec(input int n);
    vec_t v;
    int rem, total, gi, eff, tk;
    bit stop, dok, got;
    logic [31:0] raw, sw, ea, ee;
    bit visit [3];
    v = VECS[n];
    for (int k = 0; k < 3; k++) begin
      poke(DESC0 + 16*k,      dstat(v, k));
      poke(DESC0 + 16*k + 4,  32'(dlen(v, k)));
      poke(DESC0 + 16*k + 8,  32'(BUF0 + 128*k + (v.mis ? 3 : 0)));
      poke(DESC0 + 16*k + 12, 32'(DESC0 + 16*((k + 1) % 3)));
      for (int w = 0; w < 32; w++) begin
        int a;
        a = BUF0 + 128*k + 4*w;
        if (v.wr) poke(a, {wpat(a+3), wpat(a+2), wpat(a+1), wpat(a)});
        else      poke(a, 32'hA5A5_A5A5);
      end
    end
    byte_count = 32'(v.bc); cmd_write = v.wr; block_size = 16'd512;
    dma_enable = 1'b1; card_data_ready = 1'b1; desc_base = DESC0;
    stat_write(32'h3FF);
    clear_logs();
    pulse_load();
    got = 1'b0; raw = '0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (xfer_done) begin got = 1'b1; raw = raw_set; break; end
    end
    @(negedge clk);
    chk(got && raw == 32'h0001_0008, "R10 raw bits", raw, 32'h0001_0008);
    chk(dma_status == (v.wr ? 32'h101 : 32'h102), "R10 dma status",
        dma_status, v.wr ? 32'h101 : 32'h102);
    // Expected walk
    rem = int'(v.bc); total = 0; gi = 0; stop = 1'b0; dok = 1'b1;
    ea = '0; ee = '0;
    for (int k = 0; k < 3; k++) begin
      visit[k] = 1'b0;
      if (!stop) begin
        visit[k] = 1'b1;
        eff = (dlen(v, k) == 0 || dlen(v, k) > MAXB) ? MAXB : dlen(v, k); // R3
        tk  = (eff < rem) ? eff : rem;                                    // R4
        for (int i = 0; i < tk; i++) begin
          int a;
          a = BUF0 + 128*k + i;
          if (v.wr) begin                                                 // R5
            if (dok && (gi >= txn || txlog[gi] != wpat(a))) begin
              dok = 1'b0; ea = {24'h0, txlog[gi[7:0]]}; ee = {24'h0, wpat(a)};
            end
          end else if (dok && peekb(a) != pat(gi)) begin                  // R6
            dok = 1'b0; ea = {24'h0, peekb(a)}; ee = {24'h0, pat(gi)};
          end
          gi++;
        end
        if (!v.wr && (tk % 4) != 0 && dok &&
            peekb(BUF0 + 128*k + tk) != 8'hA5) begin                      // R6 enables
          dok = 1'b0; ea = {24'h0, peekb(BUF0 + 128*k + tk)}; ee = 32'hA5;
        end
        rem -= tk; total += tk;
        if (v.last[k] || rem == 0) stop = 1'b1;                           // R8 R9
      end
    end
    if (v.wr && dok && txn != total) begin dok = 1'b0; ea = 32'(txn); ee = 32'(total); end
    chk(dok, v.wr ? "R5 card byte stream" : "R6 buffer contents", ea, ee);
    dok = 1'b1; ea = '0; ee = '0;
    for (int k = 0; k < 3; k++) begin
      sw = visit[k] ? (dstat(v, k) & 32'h7FFF_FFFF) : dstat(v, k);         // R7 R9
      if (dok && mem[(DESC0 + 16*k) >> 2] != sw) begin
        dok = 1'b0; ea = mem[(DESC0 + 16*k) >> 2]; ee = sw;
      end
    end
    chk(dok, "R7 status write-back", ea, ee);
    chk(msum == total && bytes_left == 32'(int'(v.bc) - total),
        "R12 moved and left", bytes_left, 32'(int'(v.bc) - total));
    if (n == 0) begin
      dok = (rdn >= 4);
      for (int w = 0; w < 4; w++)
        if (rdlog[w] != 32'(DESC0 + 4*w)) dok = 1'b0;
      chk(dok, "R2 descriptor fetch order", rdlog[1], 32'(DESC0 + 4));
    end
  endtask

  task automatic gate_case(input string tag, input bit en, input int bc,
                           input int bs, input bit wr, input bit rdy);
    stat_write(32'h3FF);
    dma_enable = en; byte_count = 32'(bc); block_size = 16'(bs);
    cmd_write = wr; card_data_ready = rdy; desc_base = DESC0;
    clear_logs();
    pulse_load();
    repeat (20) @(negedge clk);
    chk(reqn == 0 && !busy && dma_status == 32'h0, tag, 32'(reqn), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk(!busy && !mem_req && !xfer_done && dma_status == 32'h0,
        "R10 reset state", dma_status, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NVEC; n++) run_vec(n);

    // R11: write-one-to-clear of bits 9:0 only; last vector was a write
    stat_write(32'h3FF);
    stat_write(32'h0);
    run_vec(0);
    stat_write(32'hFFFF_FC00);
    chk(dma_status == 32'h101, "R11 upper bits ignored", dma_status, 32'h101);
    stat_write(32'h0000_0001);
    chk(dma_status == 32'h100, "R11 clear written one", dma_status, 32'h100);

    // R1: start gating
    gate_case("R1 dma disabled",   1'b0, 8, 512, 1'b1, 1'b1);
    gate_case("R1 zero byte count", 1'b1, 0, 512, 1'b1, 1'b1);
    gate_case("R1 zero block size", 1'b1, 8, 0,   1'b1, 1'b1);
    gate_case("R1 read not ready",  1'b1, 8, 512, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule